// File: doc/BRIEF.md
# Burst-Count Memory Write Master

This block moves a stream of wide sample words into memory over the write half of an AXI4 port. A controller sets a base address and a burst count, then pulses a start line. The block then issues that many fixed-length incrementing bursts, back to back, to consecutive 512-byte regions starting at the base address. Write data comes from a valid/ready input stream, which normally sits behind a FIFO.

Backpressure works in both directions. The stream is consumed only on a write-data handshake, so a stalled memory holds the stream back. An empty stream drops write-valid until data arrives. Write data for a burst never runs ahead of that burst's accepted address. At most four bursts may be in flight at once, meaning their address is accepted but their response has not returned. Address issue pauses at that limit.

When the last write response of a run has been taken, a one-cycle completion pulse is raised. A bandwidth timer can use this pulse as its stop point. A sticky error flag records any response that was not OKAY during the run.

Top module: `burst_wr_master`

## Requirements
- R1: After reset, the address, data and response channels are idle: `m_awvalid`, `m_wvalid` and `s_ready` are 0, and `done_o` and `err_o` are 0.
- R2: Each address beat has burst type INCR (`m_awburst` = 2'b01), `m_awlen` = 15 and `m_awsize` = 5 (32 bytes). Burst k of a run (from 0) has address base + 512·k, and bursts are issued in that order.
- R3: Every burst has exactly 16 data beats and `m_wlast` is 1 on the 16th beat only. The beats carry the input stream words in arrival order. `m_wvalid` is 1 only while `s_valid` is 1. `s_ready` is 1 only when a data beat is accepted in the same cycle.
- R4: The count of bursts whose address has been accepted but whose response has not been received never exceeds 4. Address issue waits while the count is 4.
- R5: No data beat of burst k is presented before the address of burst k has been accepted.
- R6: A run issues exactly the programmed number of bursts. `done_o` is high for exactly one cycle, in the cycle after the handshake of the run's last write response.
- R7: A start with a burst count of 0 issues no address and raises `done_o` for one cycle in the cycle after the start.
- R8: A start pulse while a run is in progress is ignored. The running count and addresses are unchanged and no extra done pulse is produced.
- R9: `err_o` becomes 1 in the cycle after a response with `m_bresp` other than 2'b00 (OKAY) and stays 1 until the next accepted start clears it.
- R10: Once `m_awvalid` is 1, it stays 1 with `m_awaddr` stable until `m_awready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a run |
| base_addr_i | input | 32 | First burst address, sampled at start |
| burst_cnt_i | input | 16 | Number of bursts, sampled at start |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky non-OKAY response flag |
| s_valid | input | 1 | Input stream word valid |
| s_ready | output | 1 | Input stream word taken |
| s_data | input | 256 | Input stream word |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Beats per burst minus one |
| m_awsize | output | 3 | Log2 of bytes per beat |
| m_awburst | output | 2 | Burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 256 | Write data |
| m_wstrb | output | 32 | Byte strobes, all ones |
| m_wlast | output | 1 | Last beat of a burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
Address, data and stream handshakes are combinational in effect. The bench checks each transfer on the clock edge where valid and ready are both high, against the address and word index it computed itself. `done_o` and `err_o` are registered one stage past the event that causes them. For each edge, the bench works out whether a last response, a zero-count start or a failing response happened there, and compares the outputs at the next edge. This pins both pulses to exactly one cycle. The run-level counts of bursts, beats and responses, and the peak number in flight, are compared once `done_o` has been seen.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axi_resp_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/bwm_aw_issue.sv
module bwm_aw_issue #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int STEP_B  = 512,
  parameter int MAX_OUT = 4,
  parameter int OUT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              run_active,
  input  logic [CNT_W-1:0]  bursts_total,
  input  logic [OUT_W-1:0]  outstanding,
  input  logic              awready,
  output logic              awvalid,
  output logic [ADDR_W-1:0] awaddr,
  output logic [CNT_W-1:0]  aw_issued,
  output logic              aw_fire
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(STEP_B);
  localparam logic [OUT_W-1:0]  OUT_LIM = OUT_W'(MAX_OUT);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  issued_q;

  assign awvalid   = run_active && (issued_q < bursts_total) && (outstanding < OUT_LIM);
  assign aw_fire   = awvalid && awready;
  assign awaddr    = addr_q;
  assign aw_issued = issued_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      issued_q <= '0;
    end else if (load) begin
      addr_q   <= base_addr;
      issued_q <= '0;
    end else if (aw_fire) begin
      addr_q   <= addr_q + STEP;
      issued_q <= issued_q + 1'b1;
    end
  end

  // R10: a presented address is held until taken
  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  // R4: no issue at the in-flight limit
  a_r4_issue_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |-> outstanding < OUT_LIM);
endmodule

// File: rtl/bwm_w_beats.sv
module bwm_w_beats #(
  parameter int CNT_W = 16,
  parameter int BEATS = 16,
  parameter int BT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] aw_issued,
  input  logic             s_valid,
  input  logic             wready,
  output logic             wvalid,
  output logic             wlast,
  output logic             s_ready,
  output logic [CNT_W-1:0] w_bursts
);
  localparam logic [BT_W-1:0] LAST_BEAT = BT_W'(BEATS - 1);

  logic [BT_W-1:0]  beat_q;
  logic [CNT_W-1:0] wb_q;
  logic             w_fire;

  assign wvalid   = s_valid && (wb_q < aw_issued);
  assign wlast    = (beat_q == LAST_BEAT);
  assign w_fire   = wvalid && wready;
  assign s_ready  = w_fire;
  assign w_bursts = wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= '0;
      wb_q   <= '0;
    end else if (load) begin
      beat_q <= '0;
      wb_q   <= '0;
    end else if (w_fire) begin
      if (wlast) begin
        beat_q <= '0;
        wb_q   <= wb_q + 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // R3: a beat after a last beat starts a new burst
  a_r3_last_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire && wlast |=> !wlast);
  // R3: a held data beat stays valid
  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready && s_valid && !load |=> wvalid || !s_valid);
endmodule

// File: rtl/bwm_b_track.sv
module bwm_b_track #(
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int OUT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run_active,
  input  logic [CNT_W-1:0] bursts_total,
  input  logic             aw_fire,
  input  logic             bvalid,
  input  logic [1:0]       bresp,
  output logic             bready,
  output logic [OUT_W-1:0] outstanding,
  output logic             last_b,
  output logic             err
);
  import bwm_pkg::*;

  logic [OUT_W-1:0] out_q;
  logic [CNT_W-1:0] got_q;
  logic             err_q;
  logic             b_fire;

  assign bready      = run_active;
  assign b_fire      = bvalid && bready;
  assign last_b      = b_fire && (got_q == bursts_total - 1'b1);
  assign outstanding = out_q;
  assign err         = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      got_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      out_q <= '0;
      got_q <= '0;
      err_q <= 1'b0;
    end else begin
      case ({aw_fire, b_fire})
        2'b10:   out_q <= out_q + 1'b1;
        2'b01:   out_q <= out_q - 1'b1;
        default: out_q <= out_q;
      endcase
      if (b_fire) begin
        got_q <= got_q + 1'b1;
        if (axi_resp_e'(bresp) != RESP_OKAY) err_q <= 1'b1;
      end
    end
  end

  // R4: in-flight count bounded
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_q <= OUT_W'(MAX_OUT));
  // R9: error flag is sticky within a run
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !load |=> err_q);
endmodule

// File: rtl/burst_wr_master.sv
module burst_wr_master #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 256,
  parameter int CNT_W   = 16,
  parameter int BEATS   = 16,
  parameter int MAX_OUT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [CNT_W-1:0]    burst_cnt_i,
  output logic                done_o,
  output logic                err_o,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);
  localparam int BYTES  = DATA_W / 8;
  localparam int STEP_B = BEATS * BYTES;
  localparam int OUT_W  = $clog2(MAX_OUT + 1);
  localparam int BT_W   = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] total_q;
  logic             accept, zero_run;
  logic [OUT_W-1:0] outstanding;
  logic [CNT_W-1:0] aw_issued, w_bursts;
  logic             aw_fire, last_b;

  assign accept   = start_i && !busy_q;
  assign zero_run = accept && (burst_cnt_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      total_q <= '0;
    end else begin
      done_q <= zero_run || last_b;
      if (accept) begin
        total_q <= burst_cnt_i;
        busy_q  <= (burst_cnt_i != '0);
      end else if (last_b) begin
        busy_q <= 1'b0;
      end
    end
  end

  bwm_aw_issue #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_B(STEP_B),
                 .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)) u_aw (
    .clk(clk), .rst_n(rst_n), .load(accept), .base_addr(base_addr_i),
    .run_active(busy_q), .bursts_total(total_q), .outstanding(outstanding),
    .awready(m_awready), .awvalid(m_awvalid), .awaddr(m_awaddr),
    .aw_issued(aw_issued), .aw_fire(aw_fire));

  bwm_w_beats #(.CNT_W(CNT_W), .BEATS(BEATS), .BT_W(BT_W)) u_w (
    .clk(clk), .rst_n(rst_n), .load(accept), .aw_issued(aw_issued),
    .s_valid(s_valid), .wready(m_wready), .wvalid(m_wvalid),
    .wlast(m_wlast), .s_ready(s_ready), .w_bursts(w_bursts));

  bwm_b_track #(.CNT_W(CNT_W), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)) u_b (
    .clk(clk), .rst_n(rst_n), .load(accept), .run_active(busy_q),
    .bursts_total(total_q), .aw_fire(aw_fire), .bvalid(m_bvalid),
    .bresp(m_bresp), .bready(m_bready), .outstanding(outstanding),
    .last_b(last_b), .err(err_o));

  assign m_awlen   = 8'(BEATS - 1);
  assign m_awsize  = 3'($clog2(BYTES));
  assign m_awburst = bwm_pkg::BURST_INCR;
  assign m_wdata   = s_data;
  assign m_wstrb   = '1;
  assign done_o    = done_q;

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: zero-count start completes next cycle
  a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_q && burst_cnt_i == '0 |=> done_o);
  // R8: start while busy leaves the programmed count alone
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i |=> $stable(total_q));
  // R3: stream consumed only with a valid word and accepting memory
  a_r3_ready_path: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> s_valid && m_wready);
  // R5: data never leads its address
  a_r5_w_behind_aw: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> w_bursts < aw_issued);
endmodule

// File: tb/burst_wr_master_tb.sv
module burst_wr_master_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  base_addr_i = '0;
  logic [15:0]  burst_cnt_i = '0;
  logic         done_o, err_o;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [255:0] s_data = '0;
  logic         m_awvalid, m_awready = 1'b0;
  logic [31:0]  m_awaddr;
  logic [7:0]   m_awlen;
  logic [2:0]   m_awsize;
  logic [1:0]   m_awburst;
  logic         m_wvalid, m_wready = 1'b0, m_wlast;
  logic [255:0] m_wdata;
  logic [31:0]  m_wstrb;
  logic         m_bvalid = 1'b0, m_bready;
  logic [1:0]   m_bresp = 2'b00;

  always #4 clk = ~clk;

  burst_wr_master u_dut (.*);

  int total = 0, bad = 0, cyc = 0;
  int aw_n = 0, w_n = 0, b_n = 0, cnt_m = 0;
  int src_idx = 0, w_tot = 0, wl_cnt = 0, b_given = 0, err_at = -1;
  int max_out = 0;
  int vpct = 80, apct = 70, wpct = 80, bpct = 60;
  logic [31:0] base_m = '0;
  logic run_m = 1'b0, err_exp = 1'b0, due_prev = 1'b0, err_prev = 1'b0;
  logic hs_s = 1'b0, hs_b = 1'b0;

  function automatic logic [255:0] pat(int i);
    logic [31:0] w;
    w = i * 32'h9E3779B9 + 32'h1357;
    return {4{w, ~w}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // edge monitor: handshakes and registered-output expectations
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (done_o !== due_prev || due_prev) chk(done_o === due_prev, "R6 done timing", done_o, due_prev);
      if (err_o !== err_prev) chk(1'b0, "R9 err flag", err_o, err_prev);
      due_prev = 1'b0;
      if (start_i && !run_m) begin
        err_exp = 1'b0;
        if (burst_cnt_i == 0) due_prev = 1'b1;
        else begin
          run_m = 1'b1; cnt_m = burst_cnt_i; base_m = base_addr_i;
          aw_n = 0; w_n = 0; b_n = 0; max_out = 0;
        end
      end
      hs_s = s_valid && s_ready;
      if (hs_s) src_idx++;
      if (m_wvalid && !s_valid) chk(1'b0, "R3 wvalid without input", 1, 0);
      if (s_ready && !(m_wvalid && m_wready)) chk(1'b0, "R3 ready without beat", 1, 0);
      if (m_wvalid && m_wready) begin
        if (w_n / 16 >= aw_n) chk(1'b0, "R5 data ahead of address", w_n / 16, aw_n);
        if (m_wdata !== pat(w_tot)) chk(1'b0, "R3 data order", m_wdata, pat(w_tot));
        if (m_wlast !== (w_n % 16 == 15)) chk(1'b0, "R3 wlast position", m_wlast, (w_n % 16 == 15));
        if (m_wlast) wl_cnt++;
        w_n++; w_tot++;
      end
      if (m_awvalid && m_awready) begin
        if (m_awaddr !== base_m + 32'(aw_n) * 512 || m_awlen !== 8'd15 || m_awsize !== 3'd5 || m_awburst !== 2'b01)
          chk(1'b0, "R2 address beat", {m_awaddr, m_awlen, m_awsize, m_awburst}, {base_m + 32'(aw_n) * 512, 8'd15, 3'd5, 2'b01});
        aw_n++;
      end
      hs_b = m_bvalid && m_bready;
      if (hs_b) begin
        b_n++;
        if (m_bresp != 2'b00) err_exp = 1'b1;
        if (run_m && b_n == cnt_m) begin due_prev = 1'b1; run_m = 1'b0; end
      end
      if (aw_n - b_n > max_out) max_out = aw_n - b_n;
      if (aw_n - b_n > 4) chk(1'b0, "R4 in-flight limit", aw_n - b_n, 4);
      err_prev = err_exp;
    end
  end

  // stimulus for the stream and the memory side
  always @(negedge clk) begin
    if (rst_n) begin
      if (!s_valid || hs_s) s_valid = ($urandom % 100) < vpct;
      s_data    = pat(src_idx);
      m_awready = ($urandom % 100) < apct;
      m_wready  = ($urandom % 100) < wpct;
      if (m_bvalid && !hs_b) m_bvalid = 1'b1;
      else if (wl_cnt > b_given && ($urandom % 100) < bpct) begin
        m_bvalid = 1'b1;
        m_bresp  = (b_given == err_at) ? 2'b10 : 2'b00;
        b_given++;
      end else m_bvalid = 1'b0;
    end
  end

  task automatic run(input logic [31:0] base, input int cnt, input bit exp_err, input bit poke_busy);
    int waits = 0;
    @(negedge clk);
    start_i = 1'b1; base_addr_i = base; burst_cnt_i = 16'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    waits = 1;
    while (!done_o && waits < 40000) begin
      if (poke_busy && waits == 20) begin
        start_i = 1'b1; base_addr_i = 32'hDEAD0000; burst_cnt_i = 16'd2;
      end else start_i = 1'b0;
      @(negedge clk);
      waits++;
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R6 done seen", done_o, 1);
    if (cnt == 0) chk(waits == 1, "R7 zero-count done delay", waits, 1);
    else begin
      chk(aw_n == cnt, "R6 burst count", aw_n, cnt);
      chk(w_n == 16 * cnt, "R3 beat count", w_n, 16 * cnt);
      chk(b_n == cnt, "R6 response count", b_n, cnt);
    end
    if (poke_busy) chk(aw_n == cnt, "R8 busy start ignored", aw_n, cnt);
    chk(err_o === exp_err, "R9 error flag at end", err_o, exp_err);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done one cycle", done_o, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(m_awvalid === 0 && m_wvalid === 0 && s_ready === 0 && done_o === 0 && err_o === 0,
        "R1 reset idle", {m_awvalid, m_wvalid, s_ready, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_awvalid === 0 && m_wvalid === 0, "R1 idle after reset", {m_awvalid, m_wvalid}, 0);
    begin
      int aw_before;
      aw_before = aw_n;
      run(32'h1000_0000, 0, 1'b0, 1'b0);            // R7
      chk(aw_n == aw_before, "R7 no address for zero count", aw_n, aw_before);
    end
    run(32'h2000_0000, 1, 1'b0, 1'b0);              // single burst
    run(32'h3000_0200, 7, 1'b0, 1'b0);              // random backpressure
    bpct = 3;                                        // slow responses: R4 limit reached
    run(32'h4000_0000, 12, 1'b0, 1'b0);
    chk(max_out == 4, "R4 limit reached under slow responses", max_out, 4);
    bpct = 60;
    run(32'h5000_0000, 10, 1'b0, 1'b1);             // R8 start while busy
    err_at = b_given + 1;
    run(32'h6000_0000, 3, 1'b1, 1'b0);              // R9 error response
    vpct = 100; apct = 100; wpct = 100; bpct = 100;
    run(32'h7000_0000, 5, 1'b0, 1'b0);              // R9 cleared at next start, full rate
    vpct = 20;
    run(32'h0000_0000, 4, 1'b0, 1'b0);              // starved stream
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule